// File: doc/BRIEF.md
# Clause-22 Management Bus Master

This block drives a two-wire management bus: it makes the MDC clock from the system clock and moves clause-22 read and write frames over a split MDIO pin (output, output enable, input). Software sets up the controller through a control word, which holds the enable bit and the clock divider. It issues each transaction through a single packed command word.

A command starts when a word with its go bit set is written to the command register. The go bit stays set while the frame is on the wire and clears itself when the frame is over. Software polls it. When a read has finished, the same word holds the 16 data bits taken from the PHY and an acknowledge flag. The flag shows whether the PHY drove the second turnaround bit low. Writes and register readback use a plain single-cycle write strobe and two always-visible read buses.

Top module: `mdio_master`

## Requirements
- R1: After reset the control readback is 0x8000_0000 (idle set, disabled, divider 0), the command readback is 0, MDC is low and the MDIO output enable is low.
- R2: With the enable bit (control bit 30) set, MDC is a square wave with a period of 2*(div+1) system clocks, where div is control bits 7:0. With the enable bit clear, MDC stays low.
- R3: Every frame is sent in this order: 32 ones, start bits 0 then 1, opcode (1,0 for a read and 0,1 for a write), the 5-bit PHY address, then the 5-bit register address. Both addresses go out MSB first.
- R4: On a write (command bit 30 = 1) the master sends turnaround 1,0 and then data bits 15:0 MSB first. It drives MDIO for all 64 bits.
- R5: On a read (command bit 30 = 0) the master releases MDIO from the first turnaround bit to the end of the frame. The 16 bits it samples after turnaround are placed MSB first in command bits 15:0.
- R6: When a read has finished, command bit 29 is 1 if MDIO was sampled 0 at the second turnaround bit, and 0 otherwise.
- R7: Command bit 31 (go) reads 1 from the accepted command write until the frame ends, then returns to 0 by itself.
- R8: Control bit 31 reads 1 exactly when no frame is in progress.
- R9: A command write while go is set has no effect on the readback or on the frame being sent.
- R10: While busy the command readback shows go, the write flag, register address in bits 25:21, PHY address in bits 20:16, and the write data (or 0 for a read) in bits 15:0. Bits 28:26 read as 0.
- R11: MDIO output and output enable change only on the system clock at which MDC falls, and the master samples MDIO at the clock at which MDC rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe, one clock |
| reg_wr_sel | input | 1 | 0 selects the control word, 1 the command word |
| reg_wdata | input | 32 | Write data |
| ctrl_rdata | output | 32 | Control readback: idle, enable, divider |
| cmd_rdata | output | 32 | Command readback: go, write, ack, addresses, data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
Directed reads and writes with fixed addresses and data patterns (all ones, alternating bits, an address of zero) check the opcode, address and turnaround encoding bit by bit against the frame the bench has built. Seeded random transactions vary the direction, both addresses, the data, the PHY's acknowledge and the divider. They tell an address swap or a bit-order error apart from a timing error, and a captured-data fault apart from an acknowledge fault. A read that the PHY leaves unanswered, and a second command sent in the middle of a frame, cover the no-acknowledge path and the ignored write. The MDC period is measured at several divider settings, and every change of the MDIO pins is checked against the falling edge of MDC.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_IDX     = 46;  // first turnaround bit
  localparam int ACK_IDX    = 47;  // second turnaround bit
  localparam int DATA_IDX   = 48;  // first data bit
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  // Bit 63 is sent first.
  function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic wr, input logic [ADDR_W-1:0] phy,
      input logic [ADDR_W-1:0] regad, input logic [DATA_W-1:0] data);
    logic [1:0] op;
    logic [1:0] ta;
    op = wr ? 2'b01 : 2'b10;
    ta = wr ? 2'b10 : 2'b11;
    return {{PRE_BITS{1'b1}}, 2'b01, op, phy, regad, ta, wr ? data : {DATA_W{1'b1}}};
  endfunction

  function automatic logic [31:0] pack_cmd(
      input logic go, input logic wr, input logic ack,
      input logic [ADDR_W-1:0] regad, input logic [ADDR_W-1:0] phy,
      input logic [DATA_W-1:0] data);
    return {go, wr, ack, 3'b000, regad, phy, data};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap     = en && (cnt_q >= div);
  assign rise_stb = wrap && !mdc_q;
  assign fall_stb = wrap && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  mdc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);

  // R2
  mdc_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_stb && !fall_stb) |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              busy,
  output logic              done,
  output logic              ack,
  output logic [DATA_W-1:0] rdata
);
  logic                  active_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] tx_q;
  logic [DATA_W-1:0]     rx_q;
  logic                  ack_q, wr_q, o_q, oe_q;
  logic [CNT_W-1:0]      smp_idx;
  logic                  last_bit;

  assign last_bit = (cnt_q == CNT_W'(FRAME_BITS));
  assign done     = active_q && fall_stb && last_bit;
  assign smp_idx  = cnt_q - 1'b1;
  assign busy     = active_q;
  assign mdio_o   = o_q;
  assign mdio_oe  = oe_q;
  assign ack      = ack_q;
  assign rdata    = rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      ack_q    <= 1'b0;
      wr_q     <= 1'b0;
      o_q      <= 1'b1;
      oe_q     <= 1'b0;
    end else if (!active_q) begin
      if (start) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        tx_q     <= build_frame(wr, phy, regad, wdata);
        wr_q     <= wr;
        ack_q    <= 1'b0;
        rx_q     <= '0;
      end
    end else if (fall_stb) begin
      if (last_bit) begin
        active_q <= 1'b0;
        oe_q     <= 1'b0;
        o_q      <= 1'b1;
      end else begin
        o_q   <= tx_q[FRAME_BITS-1];
        tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b0};
        oe_q  <= wr_q || (cnt_q < CNT_W'(TA_IDX));
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (rise_stb && cnt_q != '0) begin
      if (smp_idx == CNT_W'(ACK_IDX))
        ack_q <= !mdio_i;
      if (smp_idx >= CNT_W'(DATA_IDX))
        rx_q <= {rx_q[DATA_W-2:0], mdio_i};
    end
  end

  // R5
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $fell(mdio_oe)) |-> !wr_q);

  // R11
  pin_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_stb |=> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic        reg_wr_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] ctrl_rdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CTRL_PAD = 30 - DIV_W;

  logic              en_q;
  logic [DIV_W-1:0]  div_q;
  logic              go_q, wr_q, ack_q;
  logic [ADDR_W-1:0] phy_q, reg_q;
  logic [DATA_W-1:0] data_q;
  logic              cmd_accept;
  logic              rise_stb, fall_stb;
  logic              eng_busy, eng_done, eng_ack;
  logic [DATA_W-1:0] eng_rdata;

  assign cmd_accept = reg_wr_en && reg_wr_sel && reg_wdata[31] && !go_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      div_q  <= '0;
      go_q   <= 1'b0;
      wr_q   <= 1'b0;
      ack_q  <= 1'b0;
      phy_q  <= '0;
      reg_q  <= '0;
      data_q <= '0;
    end else begin
      if (reg_wr_en && !reg_wr_sel) begin
        en_q  <= reg_wdata[30];
        div_q <= reg_wdata[DIV_W-1:0];
      end
      if (cmd_accept) begin
        go_q   <= 1'b1;
        wr_q   <= reg_wdata[30];
        ack_q  <= 1'b0;
        reg_q  <= reg_wdata[25:21];
        phy_q  <= reg_wdata[20:16];
        data_q <= reg_wdata[30] ? reg_wdata[15:0] : '0;
      end else if (eng_done) begin
        go_q <= 1'b0;
        if (!wr_q) begin
          ack_q  <= eng_ack;
          data_q <= eng_rdata;
        end
      end
    end
  end

  assign ctrl_rdata = {!eng_busy, en_q, {CTRL_PAD{1'b0}}, div_q};
  assign cmd_rdata  = pack_cmd(go_q, wr_q, ack_q, reg_q, phy_q, data_q);

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(en_q), .div(div_q),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame u_frame (
    .clk(clk), .rst_n(rst_n), .start(cmd_accept),
    .wr(reg_wdata[30]), .phy(reg_wdata[20:16]), .regad(reg_wdata[25:21]),
    .wdata(reg_wdata[15:0]), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .busy(eng_busy), .done(eng_done), .ack(eng_ack), .rdata(eng_rdata)
  );

  // R8
  idle_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_q == eng_busy);

  // R7
  go_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && !eng_done) |=> go_q);

  // R9
  cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && !eng_done) |=> ($stable(phy_q) && $stable(reg_q) && $stable(wr_q) && $stable(data_q)));
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0, reg_wr_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] ctrl_rdata, cmd_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  int total = 0, bad = 0;

  always #4 clk = !clk;

  mdio_master dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .cmd_rdata(cmd_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model and pin monitor, evaluated 1 ns after each clock edge
  logic [63:0] cap;
  int ncap = 0, rb = 0;
  logic phy_rd = 1'b0, phy_ack = 1'b1;
  logic [15:0] phy_data = '0;
  logic prev_mdc = 1'b0, prev_o = 1'b1, prev_oe = 1'b0;
  int bad_edges = 0, since_rise = 0, last_per = 0;

  always begin
    @(posedge clk);
    #1;
    since_rise++;
    if (mdc && !prev_mdc) begin
      last_per = since_rise;
      since_rise = 0;
      if (mdio_oe) begin
        cap = {cap[62:0], mdio_o};
        ncap++;
      end
    end
    if (!(prev_mdc && !mdc) && ((mdio_o != prev_o) || (mdio_oe != prev_oe)))
      bad_edges++;
    if (prev_mdc && !mdc) begin
      if (phy_rd && ncap >= 46 && !mdio_oe) begin
        if (rb == 0) mdio_i = 1'b1;
        else if (rb == 1) mdio_i = !phy_ack;
        else if (rb < 18) mdio_i = phy_ack ? phy_data[17-rb] : 1'b1;
        else mdio_i = 1'b1;
        rb++;
      end else begin
        mdio_i = 1'b1;
      end
    end
    prev_mdc = mdc;
    prev_o = mdio_o;
    prev_oe = mdio_oe;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [45:0] exp_head(input logic wr, input logic [4:0] phy, input logic [4:0] rg);
    logic [45:0] h;
    h = '1;
    h[13:12] = 2'b01;
    h[11:10] = wr ? 2'b01 : 2'b10;
    h[9:5] = phy;
    h[4:0] = rg;
    return h;
  endfunction

  function automatic logic [31:0] exp_word(input logic go, input logic wr, input logic ack,
      input logic [4:0] rg, input logic [4:0] phy, input logic [15:0] d);
    logic [31:0] w;
    w = '0;
    w[31] = go; w[30] = wr; w[29] = ack;
    w[25:21] = rg; w[20:16] = phy; w[15:0] = d;
    return w;
  endfunction

  task automatic reg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_idle(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!cmd_rdata[31]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_cmd(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] d, input logic ack, input bool_intrude);
    bit ok;
    logic [31:0] busy_word, fin_word;
    logic [15:0] rd_exp;
    ncap = 0; rb = 0; cap = '0;
    phy_rd = !wr; phy_ack = ack; phy_data = d;
    reg_write(1'b1, exp_word(1'b1, wr, 1'b0, rg, phy, d));
    busy_word = exp_word(1'b1, wr, 1'b0, rg, phy, wr ? d : 16'h0);
    chk(cmd_rdata == busy_word, "R10 busy readback", cmd_rdata, busy_word);
    chk(ctrl_rdata[31] == 1'b0, "R8 idle low while busy", ctrl_rdata, 0);
    if (bool_intrude) begin
      repeat (40) @(negedge clk);
      reg_write(1'b1, exp_word(1'b1, !wr, 1'b0, ~rg, ~phy, ~d));
      chk(cmd_rdata == busy_word, "R9 write while busy ignored", cmd_rdata, busy_word);
    end
    wait_idle(ok);
    chk(ok, "R7 go clears", cmd_rdata, 0);
    chk(ctrl_rdata[31] == 1'b1, "R8 idle after frame", ctrl_rdata, 32'h8000_0000);
    if (wr) begin
      chk(ncap == 64, "R4 driven bit count", ncap, 64);
      chk(cap[63:18] == exp_head(1'b1, phy, rg), "R3 write header", cap[63:18], exp_head(1'b1, phy, rg));
      chk(cap[17:0] == {2'b10, d}, "R4 turnaround and data", cap[17:0], {2'b10, d});
      fin_word = exp_word(1'b0, 1'b1, 1'b0, rg, phy, d);
    end else begin
      chk(ncap == 46, "R5 released after header", ncap, 46);
      chk(cap[45:0] == exp_head(1'b0, phy, rg), "R3 read header", cap[45:0], exp_head(1'b0, phy, rg));
      rd_exp = ack ? d : 16'hFFFF;
      fin_word = exp_word(1'b0, 1'b0, ack, rg, phy, rd_exp);
      chk(cmd_rdata[29] == ack, "R6 ack flag", cmd_rdata[29], ack);
      chk(cmd_rdata[15:0] == rd_exp, "R5 read data", cmd_rdata[15:0], rd_exp);
    end
    chk(cmd_rdata == fin_word, "R10 final word", cmd_rdata, fin_word);
  endtask

  task automatic check_period(input logic [7:0] dv);
    int exp_p;
    reg_write(1'b0, {2'b01, 22'b0, dv});
    repeat (20 * (dv + 2)) @(negedge clk);
    exp_p = 2 * (dv + 1);
    chk(last_per == exp_p, "R2 mdc period", last_per, exp_p);
    chk(ctrl_rdata == {2'b11, 22'b0, dv}, "R2 control readback", ctrl_rdata, {2'b11, 22'b0, dv});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit mdc_seen;
    logic [31:0] seed;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl_rdata == 32'h8000_0000, "R1 control reset", ctrl_rdata, 32'h8000_0000);
    chk(cmd_rdata == 32'h0, "R1 command reset", cmd_rdata, 0);
    chk(!mdc && !mdio_oe, "R1 pins reset", {mdc, mdio_oe}, 0);
    // disabled: mdc stays low
    mdc_seen = 1'b0;
    repeat (30) begin @(negedge clk); if (mdc) mdc_seen = 1'b1; end
    chk(!mdc_seen, "R2 mdc low when disabled", mdc_seen, 0);

    check_period(8'd0);
    check_period(8'd3);
    check_period(8'd1);

    // directed corner cases
    run_cmd(1'b1, 5'h1F, 5'h1F, 16'hFFFF, 1'b1, 1'b0);
    run_cmd(1'b1, 5'h00, 5'h15, 16'hA55A, 1'b1, 1'b0);
    run_cmd(1'b0, 5'h0A, 5'h01, 16'h5AC3, 1'b1, 1'b0);
    run_cmd(1'b0, 5'h03, 5'h1E, 16'h1234, 1'b0, 1'b0);
    run_cmd(1'b0, 5'h11, 5'h07, 16'h8001, 1'b1, 1'b1);
    run_cmd(1'b1, 5'h05, 5'h09, 16'h0F0F, 1'b1, 1'b1);

    seed = $urandom(32'd1234);
    for (int t = 0; t < 8; t++) begin
      logic [7:0] dv;
      dv = 8'($urandom_range(0, 3));
      reg_write(1'b0, {2'b01, 22'b0, dv});
      run_cmd(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
              ($urandom_range(0, 3) != 0), 1'b0);
    end

    chk(bad_edges == 0, "R11 pins change only at mdc fall", bad_edges, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule